// File: doc/BRIEF.md
# Floppy Controller Host Access Port

This block is the processor-facing side of a floppy disk controller. It decodes an 8-bit I/O address, an address-enable qualifier, an active-low chip select, and active-low read and write strobes. From these it steers each access to one of two targets. The first is a read-only status byte. The second is a one-byte data register that carries bytes in either direction.

Two handshake flags tell the host when the data register may be touched and in which direction. The first is the ready flag (bit 7 of the status byte). The second is the direction flag (bit 6 of the status byte). Whenever the host completes a data-register access, the ready flag drops. It stays low until the controller core has dealt with the byte and a fixed settling delay has passed.

The core side is a plain pair of valid/ready byte channels. One channel carries bytes from the core to the host. The other carries bytes from the host to the core.

Top module: `fdc_host_port`

## Requirements
- R1: An access is decoded only when `cs_n` is 0, `aen` is 0 and `addr[7:1]` matches `PORT_BASE[7:1]` (default 8'hF4: bits 7..4 and bit 2 high, bits 3 and 1 low). Otherwise `dout_oe` stays 0 and no write takes effect.
- R2: A read with `addr[0]`=0, `rd_n`=0 and `wr_n`=1 returns the status byte on `dout`. The status byte is {ready, direction, `core_flags[1:0]`, `drive_busy[3:0]`}.
- R3: A read with `addr[0]`=1, `rd_n`=0 and `wr_n`=1 returns the data register on `dout`.
- R4: A write with `addr[0]`=1, made while ready=1 and direction=0, is offered to the core on `rx_byte` with `rx_valid`=1. This happens on the clock edge after `wr_n` rises.
- R5: Two kinds of access are prohibited: a write with `addr[0]`=0, and any cycle with `rd_n` and `wr_n` both low. Neither changes any state, and `dout_oe` stays 0 while both strobes are low.
- R6: After reset, ready=1, direction=0, `rx_valid`=0 and `dout_oe`=0.
- R7: Ready drops on the clock edge after the strobe of an accepted data read or data write ends.
- R8: Once the core takes a host byte (`rx_valid` and `rx_ready` both high at an edge), ready rises exactly `RQM_DELAY` clock edges later, with direction=0.
- R9: A core byte accepted on the core-to-host channel sets direction=1 and clears ready. Ready rises `RQM_DELAY` edges later. A host read of that byte then sets direction=0, and ready rises again `RQM_DELAY` edges after that.
- R10: The status byte can be read while ready is 0, and reading it changes no state.
- R11: A data access that does not match the handshake has no effect. This covers any data access while ready=0, and a data write while direction=1.
- R12: `dout_oe` is 1 only during a decoded read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | I/O address; bit 0 picks status (0) or data (1) |
| aen | input | 1 | Address-enable qualifier; access decoded only when 0 |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data |
| dout_oe | output | 1 | Drive enable for the host data bus |
| core_flags | input | 2 | Core busy flags shown in status bits 5:4 |
| drive_busy | input | 4 | Per-drive busy flags shown in status bits 3:0 |
| tx_valid | input | 1 | Core offers a byte for the host |
| tx_byte | input | 8 | Byte offered by the core |
| tx_ready | output | 1 | Port accepts the core byte |
| rx_valid | output | 1 | Host-written byte waiting for the core |
| rx_byte | output | 8 | Host-written byte |
| rx_ready | input | 1 | Core consumes the host byte |

## Verification
If the ready or direction flag went wrong internally, the next status read would show it at once in bits 7:6. The error would also show as a lost or duplicated byte on the core channels within one access. A broken settling counter moves the rising edge of ready away from the exact cycle the bench expects, so the delay is checked edge by edge. Ignored and prohibited accesses are shown to be harmless by reading the status byte and watching `rx_valid` and `rx_byte` right after them.

// File: rtl/fdc_host_port.sv
module fdc_host_port #(
  parameter int          RQM_DELAY = 4,
  parameter logic [7:0]  PORT_BASE = 8'hF4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] addr,
  input  logic       aen,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       dout_oe,
  input  logic [1:0] core_flags,
  input  logic [3:0] drive_busy,
  input  logic       tx_valid,
  input  logic [7:0] tx_byte,
  output logic       tx_ready,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  input  logic       rx_ready
);
  localparam int         CW       = $clog2(RQM_DELAY + 1);
  localparam logic [7:0] SEL_MASK = 8'hFE;
  localparam logic [CW-1:0] DLY   = CW'(RQM_DELAY);

  logic          rqm, dio, rx_pend, rd_prev, wr_prev;
  logic [7:0]    data_reg, wr_hold;
  logic [CW-1:0] cnt;

  wire hit    = !cs_n && !aen && ((addr & SEL_MASK) == (PORT_BASE & SEL_MASK));
  wire rd_cyc = hit && !rd_n && wr_n;
  wire dat_rd = rd_cyc && addr[0];
  wire dat_wr = hit && addr[0] && rd_n && !wr_n;
  wire rd_end = rd_prev && !dat_rd;
  wire wr_end = wr_prev && !dat_wr;
  wire host_take = rd_end && rqm && dio;
  wire host_give = wr_end && rqm && !dio;
  wire cnt_run   = cnt != '0;
  wire rx_fire   = rx_pend && rx_ready;
  wire tx_fire   = tx_valid && tx_ready;

  assign dout     = addr[0] ? data_reg : {rqm, dio, core_flags, drive_busy};
  assign dout_oe  = rd_cyc;
  assign tx_ready = !rx_pend && !cnt_run && !(rqm && dio) && !dat_wr && !wr_prev;
  assign rx_valid = rx_pend;
  assign rx_byte  = data_reg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rqm <= 1'b1; dio <= 1'b0; rx_pend <= 1'b0;
      rd_prev <= 1'b0; wr_prev <= 1'b0;
      data_reg <= '0; wr_hold <= '0; cnt <= '0;
    end else begin
      rd_prev <= dat_rd;
      wr_prev <= dat_wr;
      if (dat_wr) wr_hold <= din;
      if (cnt_run) begin
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) rqm <= 1'b1;
      end
      if (host_take) begin
        rqm <= 1'b0; dio <= 1'b0; cnt <= DLY;
      end
      if (host_give) begin
        rqm <= 1'b0; data_reg <= wr_hold; rx_pend <= 1'b1;
      end
      if (rx_fire) begin
        rx_pend <= 1'b0; cnt <= DLY;
      end
      if (tx_fire) begin
        data_reg <= tx_byte; dio <= 1'b1; rqm <= 1'b0; cnt <= DLY;
      end
    end
  end

  assert_oe_only_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> (!cs_n && !aen && !rd_n && wr_n));
  assert_both_strobes_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && !wr_n) |-> !dout_oe);
  assert_pending_not_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !rqm);
  assert_read_drops_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_take |=> (!rqm && !dio));
  assert_core_byte_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fire |=> (dio && !rqm));
  assert_ready_after_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rqm) |-> $past(cnt) == CW'(1));
endmodule

// File: tb/fdc_host_port_tb.sv
module fdc_host_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam logic [7:0] BASE = 8'hF4;

  logic clk = 0, rst_n = 0;
  logic [7:0] addr = BASE, din = 0, tx_byte = 0;
  logic aen = 0, cs_n = 1, rd_n = 1, wr_n = 1, tx_valid = 0, rx_ready = 0;
  logic [1:0] core_flags = 0;
  logic [3:0] drive_busy = 0;
  logic [7:0] dout, rx_byte;
  logic dout_oe, tx_ready, rx_valid;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdc_host_port #(.RQM_DELAY(N), .PORT_BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .aen(aen), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .din(din), .dout(dout), .dout_oe(dout_oe), .core_flags(core_flags),
    .drive_busy(drive_busy), .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic peek(output logic [7:0] st);
    addr = BASE; cs_n = 0; rd_n = 0; #1;
    st = dout; rd_n = 1; cs_n = 1;
  endtask

  task automatic host_read(input logic a0, output logic [7:0] v, output logic oe);
    @(negedge clk); addr = BASE | {7'd0, a0}; cs_n = 0; rd_n = 0; #1;
    v = dout; oe = dout_oe;
    @(negedge clk); rd_n = 1; cs_n = 1;
  endtask

  task automatic host_write(input logic a0, input logic [7:0] b);
    @(negedge clk); addr = BASE | {7'd0, a0}; din = b; cs_n = 0; wr_n = 0;
    @(negedge clk); wr_n = 1; cs_n = 1;
  endtask

  task automatic t_reset;
    logic [7:0] st;
    @(negedge clk);
    check(dout_oe == 0, "R6 oe idle", dout_oe, 0);
    check(rx_valid == 0, "R6 rx_valid", rx_valid, 0);
    peek(st);
    check(st == 8'h80, "R6 status after reset", st, 8'h80);
  endtask

  task automatic t_decode;
    logic [7:0] v, st; logic oe;
    addr = BASE | 8'h08; @(negedge clk); cs_n = 0; rd_n = 0; #1;
    check(dout_oe == 0, "R1 wrong address no drive", dout_oe, 0);
    rd_n = 1; cs_n = 1; aen = 1;
    host_read(1'b0, v, oe);
    check(oe == 0, "R1 aen high no drive", oe, 0);
    host_write(1'b1, 8'h55);
    aen = 0;
    @(negedge clk); @(negedge clk);
    check(rx_valid == 0, "R1 write with aen ignored", rx_valid, 0);
    peek(st);
    check(st == 8'h80, "R1 state kept", st, 8'h80);
  endtask

  task automatic t_status;
    logic [7:0] v; logic oe;
    core_flags = 2'b10; drive_busy = 4'b0101;
    host_read(1'b0, v, oe);
    check(oe == 1 && v == 8'hA5, "R2 status byte", v, 8'hA5);
    check(oe == 1, "R12 oe during read", oe, 1);
    core_flags = 0; drive_busy = 0;
  endtask

  task automatic t_write_path;
    logic [7:0] st;
    host_write(1'b1, 8'h3C);
    @(negedge clk);
    check(rx_valid == 1 && rx_byte == 8'h3C, "R4 host byte to core", rx_byte, 8'h3C);
    peek(st);
    check(st[7] == 0, "R7 ready low after write", st[7], 0);
    check(st == 8'h00, "R10 status readable while busy", st, 8'h00);
    host_write(1'b1, 8'h99);
    @(negedge clk);
    check(rx_byte == 8'h3C && rx_valid, "R11 write while not ready", rx_byte, 8'h3C);
    rx_ready = 1;
    @(negedge clk); rx_ready = 0;
    check(rx_valid == 0, "R8 byte consumed", rx_valid, 0);
    repeat (N-1) @(negedge clk);
    peek(st);
    check(st[7] == 0, "R8 ready not early", st[7], 0);
    @(negedge clk);
    peek(st);
    check(st == 8'h80, "R8 ready after delay", st, 8'h80);
  endtask

  task automatic t_prohibited;
    logic [7:0] st;
    host_write(1'b0, 8'h77);
    @(negedge clk); @(negedge clk);
    check(rx_valid == 0, "R5 write to status ignored", rx_valid, 0);
    peek(st);
    check(st == 8'h80, "R5 status unchanged", st, 8'h80);
    @(negedge clk); addr = BASE | 8'h01; din = 8'h66; cs_n = 0; rd_n = 0; wr_n = 0; #1;
    check(dout_oe == 0, "R5 both strobes no drive", dout_oe, 0);
    @(negedge clk); rd_n = 1; wr_n = 1; cs_n = 1;
    @(negedge clk); @(negedge clk);
    check(rx_valid == 0, "R5 both strobes no write", rx_valid, 0);
  endtask

  task automatic t_core_read;
    logic [7:0] st, v; logic oe;
    @(negedge clk);
    check(tx_ready == 1, "R9 core channel open", tx_ready, 1);
    tx_valid = 1; tx_byte = 8'hC3;
    @(negedge clk); tx_valid = 0;
    peek(st);
    check(st[7:6] == 2'b01, "R9 direction set ready low", st[7:6], 2'b01);
    repeat (N-1) @(negedge clk);
    peek(st);
    check(st[7] == 0, "R9 ready not early", st[7], 0);
    @(negedge clk);
    peek(st);
    check(st[7:6] == 2'b11, "R9 ready for host read", st[7:6], 2'b11);
    host_write(1'b1, 8'h11);
    @(negedge clk);
    peek(st);
    check(rx_valid == 0 && st[7:6] == 2'b11, "R11 write in read direction", st, 8'hC0);
    host_read(1'b1, v, oe);
    check(oe == 1 && v == 8'hC3, "R3 data register read", v, 8'hC3);
    @(negedge clk);
    peek(st);
    check(st[7:6] == 2'b00, "R7 ready low after read", st[7:6], 0);
    check(tx_ready == 0, "R9 no core byte during delay", tx_ready, 0);
    host_read(1'b1, v, oe);
    @(negedge clk);
    peek(st);
    check(st[7:6] == 2'b00, "R11 read while not ready", st[7:6], 0);
    repeat (N) @(negedge clk);
    peek(st);
    check(st == 8'h80, "R9 ready for next write", st, 8'h80);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_decode();
    t_status();
    t_write_path();
    t_prohibited();
    t_core_read();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule